// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative cache of page-table entries. A lookup presents a virtual page number, the address-space tag of the running process and an access type; one clock edge later the block reports a hit with the physical frame number, a miss (the frame must come from the in-memory table), or a protection fault. A fault is a hit on a read-only entry by a write. The frame number is still shown so that it can be inspected.

Entries are installed through a refill port after a miss is resolved elsewhere. Each entry holds a page number, an address-space tag, a frame number, a global flag and a writable flag. A global entry matches any address-space tag. A flush request, issued when the running process changes, drops every non-global entry and keeps the global ones.

A refill goes to the slot that already holds a conflicting translation if there is one. Otherwise it goes to the lowest empty slot, and otherwise to the slot named by a rotating pointer. A flush and a refill in the same cycle act in that order, so the new entry survives.

Top module: `asid_tlb`

## Requirements
- R1: A lookup (`lk_valid`=1) is answered after exactly one rising edge. A matching valid entry gives `rsp_hit`=1 with its frame on `rsp_pfn`. No match gives `rsp_miss`=1 and `rsp_pfn`=0. The lookup sees the entries as they stood before that edge.
- R2: A non-global entry matches only when both its page number and its address-space tag equal the lookup's.
- R3: A global entry matches on page number alone, whatever the lookup's address-space tag.
- R4: `fl_req`=1 invalidates every non-global entry at the edge and leaves global entries intact.
- R5: A write lookup (`lk_write`=1) that matches an entry with writable=0 gives `rsp_fault`=1 and `rsp_hit`=0, with that entry's frame on `rsp_pfn`.
- R6: A read lookup (`lk_write`=0) that matches is a hit whatever the writable flag. A write lookup that matches a writable entry is a hit.
- R7: A refill with no conflicting entry is placed in the lowest-numbered invalid slot when one exists. The rotating pointer does not move.
- R8: When every slot is valid and there is no conflict, a refill replaces the slot named by the rotating pointer. The pointer then advances by one and wraps after the last slot.
- R9: A refill conflicts with a valid entry of the same page number if the tags are equal, or if either the entry or the refill is global. The conflicting entry is overwritten, so no lookup can match two entries.
- R10: When `fl_req` and `rf_valid` are both 1 in one cycle, the flush applies first. The refilled entry stays valid even when it is non-global.
- R11: Synchronous reset (`rst`=1) invalidates all entries, sets the rotating pointer to slot 0 and clears all response outputs.
- R12: `rsp_hit`, `rsp_miss` and `rsp_fault` are never asserted together. All three are 0, and `rsp_pfn` is 0, in the cycle after an edge with `lk_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number of the lookup |
| lk_asid | input | 8 | Address-space tag of the running process |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| rsp_hit | output | 1 | Registered: translation granted |
| rsp_miss | output | 1 | Registered: no matching entry |
| rsp_fault | output | 1 | Registered: write to a read-only entry |
| rsp_pfn | output | 20 | Registered frame number of the matched entry, else 0 |
| fl_req | input | 1 | Flush non-global entries |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Refill page number |
| rf_asid | input | 8 | Refill address-space tag |
| rf_pfn | input | 20 | Refill frame number |
| rf_global | input | 1 | Refill entry is global (kernel) |
| rf_writable | input | 1 | Refill entry allows writes |

## Verification
A stale valid bit shows up as a hit where a miss is due, on the lookup after the flush or eviction that should have removed the entry. That is one edge after the offending update. A slot-selection error shows up less directly. A wrong victim is visible only when a later lookup misses a page that should have stayed, so the bench fills the buffer completely and then probes every page after each replacement. A bad overwrite of a conflicting entry shows up as a stale frame number, or, through the checker, as two simultaneous matches.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_PFN_W   = 20;

  // Access is allowed for reads always, for writes only on writable entries.
  function automatic logic access_ok(input logic writable, input logic is_write);
    return writable | ~is_write;
  endfunction

  // Next rotating pointer value, wrapping at the slot count.
  function automatic int unsigned ptr_next(input int unsigned cur, input int unsigned slots);
    return (cur + 1 >= slots) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic [N-1:0]             ent_valid,
  input  logic [N-1:0]             ent_glob,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  input  logic                     q_any_asid,
  output logic [N-1:0]             match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_vpn[i] == q_vpn) &&
                      (ent_glob[i] || q_any_asid || (ent_asid[i] == q_asid));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     live,
  input  logic [N-1:0]     dup,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] sel,
  output logic             use_ptr
);
  logic [IDX_W-1:0] dup_idx, free_idx;
  logic             dup_any, free_any;

  always_comb begin
    dup_idx  = '0;
    dup_any  = 1'b0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (dup[i]) begin
        dup_idx = IDX_W'(i);
        dup_any = 1'b1;
      end
      if (!live[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    use_ptr = 1'b0;
    if (dup_any)       sel = dup_idx;
    else if (free_any) sel = free_idx;
    else begin
      sel     = ptr;
      use_ptr = 1'b1;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned N_ENT  = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned VPN_W  = tlb_pkg::DEF_VPN_W,
  parameter int unsigned ASID_W = tlb_pkg::DEF_ASID_W,
  parameter int unsigned PFN_W  = tlb_pkg::DEF_PFN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  input  logic              fl_req,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic              rf_global,
  input  logic              rf_writable
);
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0]             ent_valid, ent_glob, ent_wr;
  logic [N_ENT-1:0][VPN_W-1:0]  ent_vpn;
  logic [N_ENT-1:0][ASID_W-1:0] ent_asid;
  logic [N_ENT-1:0][PFN_W-1:0]  ent_pfn;
  logic [IDX_W-1:0]             rr_ptr;

  // Named internal events for the checker.
  logic [N_ENT-1:0] lk_match;
  logic [N_ENT-1:0] rf_dup;
  logic [N_ENT-1:0] live_after_flush;
  logic [N_ENT-1:0] user_live;
  logic             lk_found, lk_perm;
  logic [PFN_W-1:0] lk_pfn;
  logic             lk_wr_flag;
  logic [IDX_W-1:0] rf_sel;
  logic             rf_use_ptr;

  assign live_after_flush = fl_req ? (ent_valid & ent_glob) : ent_valid;
  assign user_live        = ent_valid & ~ent_glob;

  tlb_match #(.N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .ent_valid (ent_valid), .ent_glob (ent_glob), .ent_vpn (ent_vpn), .ent_asid (ent_asid),
    .q_vpn (lk_vpn), .q_asid (lk_asid), .q_any_asid (1'b0), .match (lk_match)
  );

  tlb_match #(.N(N_ENT), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
    .ent_valid (live_after_flush), .ent_glob (ent_glob), .ent_vpn (ent_vpn), .ent_asid (ent_asid),
    .q_vpn (rf_vpn), .q_asid (rf_asid), .q_any_asid (rf_global), .match (rf_dup)
  );

  tlb_victim #(.N(N_ENT)) u_victim (
    .live (live_after_flush), .dup (rf_dup), .ptr (rr_ptr),
    .sel (rf_sel), .use_ptr (rf_use_ptr)
  );

  // One-hot select of the matching entry's fields.
  always_comb begin
    lk_pfn     = '0;
    lk_wr_flag = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (lk_match[i]) begin
        lk_pfn     = lk_pfn | ent_pfn[i];
        lk_wr_flag = lk_wr_flag | ent_wr[i];
      end
    end
  end

  assign lk_found = |lk_match;
  assign lk_perm  = tlb_pkg::access_ok(lk_wr_flag, lk_write);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_hit   <= lk_valid && lk_found && lk_perm;
      rsp_fault <= lk_valid && lk_found && !lk_perm;
      rsp_miss  <= lk_valid && !lk_found;
      rsp_pfn   <= lk_valid ? lk_pfn : '0;

      ent_valid <= live_after_flush;
      if (rf_valid) begin
        ent_valid[rf_sel] <= 1'b1;
        ent_vpn[rf_sel]   <= rf_vpn;
        ent_asid[rf_sel]  <= rf_asid;
        ent_pfn[rf_sel]   <= rf_pfn;
        ent_glob[rf_sel]  <= rf_global;
        ent_wr[rf_sel]    <= rf_writable;
        if (rf_use_ptr)
          rr_ptr <= IDX_W'(tlb_pkg::ptr_next(32'(rr_ptr), N_ENT));
      end
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         lk_valid,
  input logic         fl_req,
  input logic         rf_valid,
  input logic         rsp_hit,
  input logic         rsp_miss,
  input logic         rsp_fault,
  input logic [N-1:0] lk_match,
  input logic [N-1:0] ent_valid,
  input logic [N-1:0] user_live
);
  // R12: the three response flags are exclusive
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_hit, rsp_miss, rsp_fault}) <= 1);

  // R12: no request, no response
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_hit && !rsp_miss && !rsp_fault);

  // R1: every request gets exactly one answer
  a_r1_answered: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rsp_hit || rsp_miss || rsp_fault));

  // R9: a lookup never matches two entries
  a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R4: flush without refill leaves no user entry
  a_r4_flush_clears: assert property (@(posedge clk) disable iff (rst)
    fl_req && !rf_valid |=> user_live == '0);

  // R10: a refill always leaves a valid entry
  a_r10_refill_kept: assert property (@(posedge clk) disable iff (rst)
    rf_valid |=> ent_valid != '0);

  // R11: reset empties the buffer
  a_r11_reset_empty: assert property (@(posedge clk)
    rst |=> ent_valid == '0 && !rsp_hit && !rsp_miss && !rsp_fault);
endmodule

bind asid_tlb tlb_checker #(.N(N_ENT)) u_chk (
  .clk (clk), .rst (rst), .lk_valid (lk_valid), .fl_req (fl_req), .rf_valid (rf_valid),
  .rsp_hit (rsp_hit), .rsp_miss (rsp_miss), .rsp_fault (rsp_fault),
  .lk_match (lk_match), .ent_valid (ent_valid), .user_live (user_live)
);

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int SLOTS = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_write, fl_req, rf_valid, rf_global, rf_writable;
  logic [19:0] lk_vpn, rf_vpn, rf_pfn;
  logic [7:0]  lk_asid, rf_asid;
  logic        rsp_hit, rsp_miss, rsp_fault;
  logic [19:0] rsp_pfn;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  asid_tlb u0 (
    .clk (clk), .rst (rst), .lk_valid (lk_valid), .lk_vpn (lk_vpn), .lk_asid (lk_asid),
    .lk_write (lk_write), .rsp_hit (rsp_hit), .rsp_miss (rsp_miss), .rsp_fault (rsp_fault),
    .rsp_pfn (rsp_pfn), .fl_req (fl_req), .rf_valid (rf_valid), .rf_vpn (rf_vpn),
    .rf_asid (rf_asid), .rf_pfn (rf_pfn), .rf_global (rf_global), .rf_writable (rf_writable)
  );

  // Reference model: a plain list of records plus a replacement cursor.
  bit      m_used [SLOTS];
  int      m_page [SLOTS];
  int      m_tag  [SLOTS];
  int      m_frame[SLOTS];
  bit      m_kern [SLOTS];
  bit      m_rw   [SLOTS];
  int      m_cursor;

  bit      e_hit, e_miss, e_fault;
  int      e_pfn;

  task automatic model_apply(input bit r, input bit lv, input int vp, input int as, input bit wr,
                             input bit fl, input bit rv, input int rvp, input int ras,
                             input int rpf, input bit rg, input bit rw);
    int slot;
    e_hit = 0; e_miss = 0; e_fault = 0; e_pfn = 0;
    if (r) begin
      foreach (m_used[k]) m_used[k] = 0;
      m_cursor = 0;
      return;
    end
    if (lv) begin
      slot = -1;
      foreach (m_used[k])
        if (m_used[k] && m_page[k] == vp && (m_kern[k] || m_tag[k] == as)) slot = k;
      if (slot < 0) e_miss = 1;
      else begin
        e_pfn = m_frame[slot];
        if (wr && !m_rw[slot]) e_fault = 1; else e_hit = 1;
      end
    end
    if (fl) foreach (m_used[k]) if (!m_kern[k]) m_used[k] = 0;
    if (rv) begin
      slot = -1;
      foreach (m_used[k])
        if (slot < 0 && m_used[k] && m_page[k] == rvp && (m_kern[k] || rg || m_tag[k] == ras))
          slot = k;
      if (slot < 0) foreach (m_used[k]) if (slot < 0 && !m_used[k]) slot = k;
      if (slot < 0) begin
        slot = m_cursor;
        m_cursor = (m_cursor + 1) % SLOTS;
      end
      m_used[slot] = 1; m_page[slot] = rvp; m_tag[slot] = ras;
      m_frame[slot] = rpf; m_kern[slot] = rg; m_rw[slot] = rw;
    end
  endtask

  task automatic step(input string tag, input bit r, input bit lv, input int vp, input int as,
                      input bit wr, input bit fl, input bit rv, input int rvp, input int ras,
                      input int rpf, input bit rg, input bit rw);
    @(negedge clk);
    rst = r; lk_valid = lv; lk_vpn = 20'(vp); lk_asid = 8'(as); lk_write = wr;
    fl_req = fl; rf_valid = rv; rf_vpn = 20'(rvp); rf_asid = 8'(ras); rf_pfn = 20'(rpf);
    rf_global = rg; rf_writable = rw;
    model_apply(r, lv, vp, as, wr, fl, rv, rvp, ras, rpf, rg, rw);
    @(posedge clk);
    #2;
    checks++;
    if (rsp_hit !== e_hit || rsp_miss !== e_miss || rsp_fault !== e_fault ||
        rsp_pfn !== 20'(e_pfn)) begin
      failures++;
      $display("FAIL %s: got hit=%b miss=%b fault=%b pfn=%h expected hit=%b miss=%b fault=%b pfn=%h",
               tag, rsp_hit, rsp_miss, rsp_fault, rsp_pfn, e_hit, e_miss, e_fault, 20'(e_pfn));
    end
  endtask

  task automatic look(input string tag, input int vp, input int as, input bit wr);
    step(tag, 0, 1, vp, as, wr, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input string tag, input int vp, input int as, input int pf,
                      input bit g, input bit w);
    step(tag, 0, 0, 0, 0, 0, 0, 1, vp, as, pf, g, w);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step("R11 reset", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R11 reset", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R12 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R1 empty miss", 'h12345, 5, 0);

    fill("R1 fill", 'h00010, 5, 'hA0010, 0, 1);
    look("R1 hit", 'h00010, 5, 0);
    look("R2 other tag", 'h00010, 6, 0);
    look("R6 write ok", 'h00010, 5, 1);
    look("R1 other page", 'h00011, 5, 0);

    fill("R3 fill kernel", 'h00F00, 0, 'hBEEF0, 1, 0);
    look("R3 any tag", 'h00F00, 9, 0);
    look("R6 read of read-only", 'h00F00, 5, 0);
    look("R5 write fault", 'h00F00, 77, 1);

    fill("R2 fill user ro", 'h00020, 6, 'hC0020, 0, 0);
    look("R5 user fault", 'h00020, 6, 1);
    step("R4 flush", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    look("R4 user gone", 'h00010, 5, 0);
    look("R4 user gone", 'h00020, 6, 0);
    look("R4 kernel kept", 'h00F00, 3, 0);

    fill("R9 first", 'h00030, 4, 'h11111, 0, 1);
    fill("R9 overwrite", 'h00030, 4, 'h22222, 0, 1);
    look("R9 new frame", 'h00030, 4, 0);
    fill("R9 global over user", 'h00030, 8, 'h33333, 1, 1);
    look("R9 global frame", 'h00030, 4, 0);

    step("R10 flush+refill", 0, 0, 0, 0, 0, 1, 1, 'h00040, 2, 'h44444, 0, 1);
    look("R10 kept", 'h00040, 2, 0);
    step("R1 lookup sees old state", 0, 1, 'h00050, 2, 0, 0, 1, 'h00050, 2, 'h55555, 0, 1);
    look("R1 then visible", 'h00050, 2, 0);

    // Fill every slot, then force rotating replacements.
    step("R11 reset again", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) fill("R7 fill free", 'h100 + k, 1, 'h7000 + k, 0, 1);
    fill("R7 fill kernel", 'h1FF, 0, 'h7FFF, 1, 1);
    for (int k = 0; k < 7; k++) look("R7 all present", 'h100 + k, 1, 0);
    for (int k = 0; k < 10; k++) begin
      fill("R8 replace", 'h200 + k, 1, 'h8000 + k, 0, 1);
      for (int j = 0; j < 7; j++) look("R8 probe old", 'h100 + j, 1, 0);
      for (int j = 0; j <= k; j++) look("R8 probe new", 'h200 + j, 1, 0);
      look("R8 probe kernel", 'h1FF, 3, 0);
    end
    step("R4 flush full", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) fill("R7 reuse free", 'h300 + k, 2, 'h9000 + k, 0, 0);
    for (int k = 0; k < 3; k++) look("R7 reuse probe", 'h300 + k, 2, 1);
    look("R7 global survives", 'h1FF, 2, 1);
    for (int k = 0; k < 6; k++) fill("R8 refill", 'h400 + k, 2, 'hA000 + k, 0, 1);
    for (int k = 0; k < 6; k++) look("R8 refill probe", 'h400 + k, 2, 0);
    for (int k = 0; k < 3; k++) look("R8 refill probe", 'h300 + k, 2, 0);
    look("R8 kernel probe", 'h1FF, 2, 0);

    step("R11 reset mid", 1, 1, 'h400, 2, 0, 0, 1, 'h999, 1, 1, 0, 1);
    look("R11 empty after reset", 'h400, 2, 0);
    look("R11 empty after reset", 'h1FF, 2, 0);
    step("R12 idle end", 0, 0, 'h1FF, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule